// File: doc/BRIEF.md
# Configurable Logic-Block Macrocell Flip-Flop

This block is the storage element of one macrocell in a programmable logic block. Static configuration inputs decide how it behaves. A clock-source field picks the clock: one of the block clocks, a product-term clock in true or inverted form, the shared product-term clock, or a grounded (never-toggling) clock. A second field picks a clock enable from four sources. The register also takes two kinds of asynchronous set and reset. One is the initialization line that the logic block fans out to all of its cells. The other is a pair of product terms local to this cell, which a configuration bit can enable.

A per-cell swap bit makes the block-level initialization line act as a preset instead of a clear. The same bit picks the value the cell takes at power-up. While the power-on input `por_n` is low, the register is held at that power-up value. After `por_n` rises, it stays held for a set number of reference-clock edges, so the selected clock cannot load data before that delay has passed. The register state is the only output.

Top module: `mcell_reg`

## Requirements
- R1: With clock-select codes 0 to 3, the register loads `d` on the rising edge of block clock 0 to 3 respectively, and edges on the other block clocks leave it unchanged.
- R2: Clock-select code 4 loads `d` on the rising edge of `pt_clk`. Code 5 loads `d` on the falling edge of `pt_clk`, and the rising edge of `pt_clk` has no effect under code 5.
- R3: Clock-select code 6 loads `d` on the rising edge of `shared_pt_clk`. Under code 7 (ground), edges on every clock source leave the register unchanged.
- R4: Clock-enable select 0 allows a load only while `pt_init_ce` is 1. Select 1 allows a load only while `pt_init_ce` is 0. Select 2 allows a load only while `shared_pt_clk` is 1. Select 3 always allows a load.
- R5: With `cfg_swap`=0, a high `blk_init` clears the register at once, with no clock edge. With `cfg_swap`=1, a high `blk_init` sets the register at once.
- R6: With `cfg_mc_sr_en`=1, `mc_set_pt` sets and `mc_rst_pt` clears the register at once. With `cfg_mc_sr_en`=0, both product terms have no effect.
- R7: When a set request and a clear request are active together, from any mix of block-level and cell-level sources, the register reads 0.
- R8: While `por_n` is low, the register holds the power-up value, which equals `cfg_swap`. After `por_n` rises, it keeps holding that value through the first POR_DELAY-1 rising edges of `ref_clk`, and clock edges in that window have no effect.
- R9: From the POR_DELAY-th rising edge of `ref_clk` after `por_n` rises, the selected clock loads `d` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that times the power-up hold delay |
| por_n | input | 1 | Power-on reset, active low |
| blk_clk | input | NUM_BLK_CLK | Block clocks of the logic block |
| pt_clk | input | 1 | Product-term clock of this cell |
| shared_pt_clk | input | 1 | Shared product-term clock; also usable as a clock enable |
| pt_init_ce | input | 1 | Product-term init/clock-enable signal |
| blk_init | input | 1 | Block-level initialization line, active high |
| mc_set_pt | input | 1 | Cell-local set product term, active high |
| mc_rst_pt | input | 1 | Cell-local reset product term, active high |
| d | input | 1 | Data input |
| cfg_clk_sel | input | CLK_SEL_W | Clock-source select (0-3 block clocks, 4 pt_clk, 5 inverted pt_clk, 6 shared, 7 ground) |
| cfg_ce_sel | input | 2 | Clock-enable source select |
| cfg_swap | input | 1 | Makes block init act as a preset and sets the power-up value to 1 |
| cfg_mc_sr_en | input | 1 | Enables the cell-local set/reset product terms |
| q | output | 1 | Registered value |

## Verification
Each clock code is exercised by pulsing its own source and also a source that must be ignored, which shows the multiplexer is selective and not merely live. For the inverted product-term clock, the rising and falling edges of `pt_clk` are checked separately, which separates polarity from plain selection. Each clock-enable source is tried at both levels. The asynchronous paths are driven one at a time with both swap settings, and then in overlapping pairs to expose which request takes priority. Power-up is run with both swap values and probed one reference edge before and one edge after the end of the hold window.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

   typedef enum logic [1:0] {
      CE_PT     = 2'd0,
      CE_PT_N   = 2'd1,
      CE_SHARED = 2'd2,
      CE_ONE    = 2'd3
   } ce_sel_e;

   typedef struct packed {
      logic set_req;
      logic clr_req;
      logic pu_val;
   } init_ctl_t;

endpackage

// File: rtl/mcell_clk_mux.sv
module mcell_clk_mux #(
   parameter  int NUM_BLK_CLK = 4,
   localparam int SEL_W       = $clog2(NUM_BLK_CLK + 4),
   localparam int NSLOT       = 2 ** SEL_W
) (
   input  logic [NUM_BLK_CLK-1:0] blk_clk,
   input  logic                   pt_clk,
   input  logic                   shared_pt_clk,
   input  logic [SEL_W-1:0]       sel,
   output logic                   sel_clk
);

   logic [NSLOT-1:0] slot;

   generate
      for (genvar k = 0; k < NSLOT; k++) begin : g_slot
         if (k < NUM_BLK_CLK) begin : g_blk
            assign slot[k] = blk_clk[k];
         end else if (k == NUM_BLK_CLK) begin : g_pt
            assign slot[k] = pt_clk;
         end else if (k == NUM_BLK_CLK + 1) begin : g_pt_n
            assign slot[k] = ~pt_clk;
         end else if (k == NUM_BLK_CLK + 2) begin : g_shared
            assign slot[k] = shared_pt_clk;
         end else begin : g_gnd
            assign slot[k] = 1'b0;
         end
      end
   endgenerate

   assign sel_clk = slot[sel];

endmodule

// File: rtl/mcell_ce_mux.sv
module mcell_ce_mux
   import mcell_pkg::*;
(
   input  logic       pt_init_ce,
   input  logic       shared_pt_clk,
   input  logic [1:0] sel,
   output logic       ce
);

   always_comb begin
      unique case (ce_sel_e'(sel))
         CE_PT:     ce = pt_init_ce;
         CE_PT_N:   ce = ~pt_init_ce;
         CE_SHARED: ce = shared_pt_clk;
         default:   ce = 1'b1;
      endcase
   end

endmodule

// File: rtl/mcell_init_merge.sv
module mcell_init_merge
   import mcell_pkg::*;
(
   input  logic      blk_init,
   input  logic      mc_set_pt,
   input  logic      mc_rst_pt,
   input  logic      cfg_swap,
   input  logic      cfg_mc_sr_en,
   output init_ctl_t ctl
);

   logic blk_as_set;
   logic blk_as_clr;

   assign blk_as_set  = blk_init & cfg_swap;
   assign blk_as_clr  = blk_init & ~cfg_swap;

   assign ctl.set_req = blk_as_set | (cfg_mc_sr_en & mc_set_pt);
   assign ctl.clr_req = blk_as_clr | (cfg_mc_sr_en & mc_rst_pt);
   assign ctl.pu_val  = cfg_swap;

endmodule

// File: rtl/mcell_por_hold.sv
module mcell_por_hold #(
   parameter int POR_DELAY = 16
) (
   input  logic ref_clk,
   input  logic por_n,
   output logic hold
);

   generate
      if (POR_DELAY < 0) begin : g_bad
         $error("mcell_por_hold: POR_DELAY must not be negative");
      end else if (POR_DELAY == 0) begin : g_nodelay
         assign hold = ~por_n;
      end else begin : g_count
         localparam int CW = $clog2(POR_DELAY + 1);
         localparam logic [CW-1:0] LAST = CW'(POR_DELAY);

         logic [CW-1:0] cnt;

         always_ff @(posedge ref_clk or negedge por_n) begin
            if (!por_n)
               cnt <= '0;
            else if (cnt != LAST)
               cnt <= cnt + 1'b1;
         end

         assign hold = ~por_n | (cnt != LAST);

         a_r8_count_in_range: assert property (
            @(posedge ref_clk) disable iff (!por_n)
            cnt <= LAST)
            else $error("a_r8_count_in_range: delay counter ran past its limit");

         a_r9_release_sticks: assert property (
            @(posedge ref_clk) disable iff (!por_n)
            !hold |=> !hold)
            else $error("a_r9_release_sticks: hold came back without a power-on reset");
      end
   endgenerate

endmodule

// File: rtl/mcell_reg.sv
module mcell_reg
   import mcell_pkg::*;
#(
   parameter  int NUM_BLK_CLK = 4,
   parameter  int POR_DELAY   = 16,
   localparam int CLK_SEL_W   = $clog2(NUM_BLK_CLK + 4)
) (
   input  logic                   ref_clk,
   input  logic                   por_n,
   input  logic [NUM_BLK_CLK-1:0] blk_clk,
   input  logic                   pt_clk,
   input  logic                   shared_pt_clk,
   input  logic                   pt_init_ce,
   input  logic                   blk_init,
   input  logic                   mc_set_pt,
   input  logic                   mc_rst_pt,
   input  logic                   d,
   input  logic [CLK_SEL_W-1:0]   cfg_clk_sel,
   input  logic [1:0]             cfg_ce_sel,
   input  logic                   cfg_swap,
   input  logic                   cfg_mc_sr_en,
   output logic                   q
);

   localparam logic [CLK_SEL_W-1:0] GND_CODE = '1;

   generate
      if (NUM_BLK_CLK < 1) begin : g_chk_clk
         $error("mcell_reg: NUM_BLK_CLK must be at least 1");
      end
   endgenerate

   logic      sel_clk;
   logic      ce;
   logic      force_pu;
   init_ctl_t ctl;

   mcell_clk_mux #(.NUM_BLK_CLK(NUM_BLK_CLK)) u_clk_mux (
      .blk_clk       (blk_clk),
      .pt_clk        (pt_clk),
      .shared_pt_clk (shared_pt_clk),
      .sel           (cfg_clk_sel),
      .sel_clk       (sel_clk)
   );

   mcell_ce_mux u_ce_mux (
      .pt_init_ce    (pt_init_ce),
      .shared_pt_clk (shared_pt_clk),
      .sel           (cfg_ce_sel),
      .ce            (ce)
   );

   mcell_init_merge u_init (
      .blk_init      (blk_init),
      .mc_set_pt     (mc_set_pt),
      .mc_rst_pt     (mc_rst_pt),
      .cfg_swap      (cfg_swap),
      .cfg_mc_sr_en  (cfg_mc_sr_en),
      .ctl           (ctl)
   );

   mcell_por_hold #(.POR_DELAY(POR_DELAY)) u_por (
      .ref_clk       (ref_clk),
      .por_n         (por_n),
      .hold          (force_pu)
   );

   // priority: power-up hold, then clear, then set, then enabled load
   always_ff @(posedge sel_clk or negedge por_n or posedge force_pu
               or posedge ctl.clr_req or posedge ctl.set_req) begin
      if (force_pu)
         q <= ctl.pu_val;
      else if (ctl.clr_req)
         q <= 1'b0;
      else if (ctl.set_req)
         q <= 1'b1;
      else if (ce)
         q <= d;
   end

   a_r8_hold_pu_value: assert property (
      @(posedge ref_clk) disable iff (!por_n)
      force_pu |-> (q == cfg_swap))
      else $error("a_r8_hold_pu_value: register left its power-up value during hold");

   a_r7_clear_wins: assert property (
      @(posedge ref_clk) disable iff (!por_n)
      (!force_pu && ctl.clr_req) |-> !q)
      else $error("a_r7_clear_wins: register is 1 while a clear is active");

   a_r6_set_takes: assert property (
      @(posedge ref_clk) disable iff (!por_n)
      (!force_pu && $rose(ctl.set_req) && !ctl.clr_req) |-> q)
      else $error("a_r6_set_takes: set request did not reach the register");

   a_r3_ground_freezes: assert property (
      @(posedge ref_clk) disable iff (!por_n)
      (cfg_clk_sel == GND_CODE && $past(cfg_clk_sel) == GND_CODE &&
       !force_pu && !$past(force_pu) &&
       !ctl.clr_req && !$past(ctl.clr_req) &&
       !ctl.set_req && !$past(ctl.set_req)) |-> $stable(q))
      else $error("a_r3_ground_freezes: register changed under the grounded clock");

endmodule

// File: tb/test_mcell_reg.sv
module test_mcell_reg;

   localparam int NBC       = 4;
   localparam int DLY       = 16;
   localparam int SW        = $clog2(NBC + 4);

   logic           ref_clk = 1'b0;
   logic           por_n   = 1'b1;
   logic [NBC-1:0] blk_clk = '0;
   logic           pt_clk = 1'b0, shared_pt_clk = 1'b0, pt_init_ce = 1'b0;
   logic           blk_init = 1'b0, mc_set_pt = 1'b0, mc_rst_pt = 1'b0, d = 1'b0;
   logic [SW-1:0]  cfg_clk_sel = '0;
   logic [1:0]     cfg_ce_sel = 2'd3;
   logic           cfg_swap = 1'b0, cfg_mc_sr_en = 1'b0;
   logic           q;

   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;
   logic exp_q = 1'b0;

   always #10 ref_clk = ~ref_clk;

   mcell_reg #(.NUM_BLK_CLK(NBC), .POR_DELAY(DLY)) i_mcell_reg (
      .ref_clk(ref_clk), .por_n(por_n), .blk_clk(blk_clk), .pt_clk(pt_clk),
      .shared_pt_clk(shared_pt_clk), .pt_init_ce(pt_init_ce), .blk_init(blk_init),
      .mc_set_pt(mc_set_pt), .mc_rst_pt(mc_rst_pt), .d(d), .cfg_clk_sel(cfg_clk_sel),
      .cfg_ce_sel(cfg_ce_sel), .cfg_swap(cfg_swap), .cfg_mc_sr_en(cfg_mc_sr_en), .q(q)
   );

   task automatic chk(input string tag, input logic exp);
      n_chk++;
      if (q !== exp) begin
         n_bad++;
         $display("FAIL %s: q=%b expected %b", tag, q, exp);
      end
   endtask

   // source ids: 0-3 block clocks, 4 pt_clk, 6 shared_pt_clk
   task automatic pulse(input int src);
      if (src < NBC) blk_clk[src] = 1'b1;
      else if (src == 4) pt_clk = 1'b1;
      else shared_pt_clk = 1'b1;
      #2;
      if (src < NBC) blk_clk[src] = 1'b0;
      else if (src == 4) pt_clk = 1'b0;
      else shared_pt_clk = 1'b0;
      #2;
   endtask

   // d is parked at the expected state so a select switch cannot corrupt it
   task automatic set_cfg(input int csel, input int esel);
      d = exp_q;
      #1;
      cfg_clk_sel = SW'(csel);
      cfg_ce_sel  = 2'(esel);
      #1;
   endtask

   task automatic power_up(input logic swap);
      @(negedge ref_clk);
      d = exp_q;
      cfg_swap = swap;
      #1;
      por_n = 1'b0;
      #2;
      exp_q = swap;
      chk("R8 held at power-up value while por_n low", exp_q);
      @(negedge ref_clk);
      por_n = 1'b1;
      repeat (DLY - 1) @(posedge ref_clk);
      @(negedge ref_clk);
      d = ~swap;
      pulse(0);
      chk("R8 clock ignored inside hold window", exp_q);
      @(posedge ref_clk);
      @(negedge ref_clk);
      pulse(0);
      exp_q = ~swap;
      chk("R9 clock loads after hold window", exp_q);
   endtask

   task automatic t_block_clocks;
      for (int k = 0; k < NBC; k++) begin
         @(negedge ref_clk);
         set_cfg(k, 3);
         d = ~exp_q;
         pulse((k + 1) % NBC);
         chk($sformatf("R1 other block clock ignored, sel %0d", k), exp_q);
         pulse(k);
         exp_q = d;
         chk($sformatf("R1 block clock %0d loads", k), exp_q);
      end
   endtask

   task automatic t_pt_clocks;
      @(negedge ref_clk);
      set_cfg(4, 3);
      d = ~exp_q;
      pulse(0);
      chk("R2 block clock ignored under pt_clk", exp_q);
      pulse(4);
      exp_q = d;
      chk("R2 pt_clk rising loads", exp_q);
      set_cfg(5, 3);
      d = ~exp_q;
      pt_clk = 1'b1;
      #2;
      chk("R2 inverted: pt_clk rise ignored", exp_q);
      pt_clk = 1'b0;
      #2;
      exp_q = d;
      chk("R2 inverted: pt_clk fall loads", exp_q);
   endtask

   task automatic t_shared_ground;
      @(negedge ref_clk);
      set_cfg(6, 3);
      d = ~exp_q;
      pulse(4);
      chk("R3 pt_clk ignored under shared clock", exp_q);
      pulse(6);
      exp_q = d;
      chk("R3 shared clock loads", exp_q);
      set_cfg(7, 3);
      d = ~exp_q;
      for (int s = 0; s < 7; s++) if (s != 5) pulse(s);
      pt_clk = 1'b1; #2; pt_clk = 1'b0; #2;
      chk("R3 ground select loads nothing", exp_q);
   endtask

   task automatic t_clock_enable;
      @(negedge ref_clk);
      set_cfg(0, 0);
      pt_init_ce = 1'b0; d = ~exp_q; pulse(0);
      chk("R4 sel0 blocked with pt_init_ce=0", exp_q);
      pt_init_ce = 1'b1; pulse(0); exp_q = d;
      chk("R4 sel0 loads with pt_init_ce=1", exp_q);
      set_cfg(0, 1);
      d = ~exp_q; pulse(0);
      chk("R4 sel1 blocked with pt_init_ce=1", exp_q);
      pt_init_ce = 1'b0; pulse(0); exp_q = d;
      chk("R4 sel1 loads with pt_init_ce=0", exp_q);
      set_cfg(0, 2);
      shared_pt_clk = 1'b0; d = ~exp_q; pulse(0);
      chk("R4 sel2 blocked with shared low", exp_q);
      shared_pt_clk = 1'b1; pulse(0); exp_q = d;
      chk("R4 sel2 loads with shared high", exp_q);
      shared_pt_clk = 1'b0;
      set_cfg(0, 3);
      pt_init_ce = 1'b1; d = ~exp_q; pulse(0); exp_q = d;
      chk("R4 sel3 always loads", exp_q);
      pt_init_ce = 1'b0;
   endtask

   task automatic t_block_init;
      @(negedge ref_clk);
      set_cfg(0, 3);
      cfg_swap = 1'b0;
      d = 1'b1; pulse(0); exp_q = 1'b1;
      blk_init = 1'b1; #2; exp_q = 1'b0;
      chk("R5 block init clears with swap=0", exp_q);
      blk_init = 1'b0; #2;
      cfg_swap = 1'b1; #1;
      d = 1'b0; pulse(0);
      chk("R5 swap=1 register loaded 0", exp_q);
      blk_init = 1'b1; #2; exp_q = 1'b1;
      chk("R5 block init sets with swap=1", exp_q);
      blk_init = 1'b0; #2;
      cfg_swap = 1'b0; #1;
   endtask

   task automatic t_cell_sr;
      @(negedge ref_clk);
      set_cfg(0, 3);
      cfg_mc_sr_en = 1'b0;
      d = 1'b0; pulse(0); exp_q = 1'b0;
      mc_set_pt = 1'b1; #2; mc_set_pt = 1'b0; #2;
      chk("R6 set term ignored when disabled", exp_q);
      d = 1'b1; pulse(0); exp_q = 1'b1;
      mc_rst_pt = 1'b1; #2; mc_rst_pt = 1'b0; #2;
      chk("R6 reset term ignored when disabled", exp_q);
      cfg_mc_sr_en = 1'b1; #1;
      mc_rst_pt = 1'b1; #2; exp_q = 1'b0;
      chk("R6 reset term clears when enabled", exp_q);
      mc_rst_pt = 1'b0; #2;
      mc_set_pt = 1'b1; #2; exp_q = 1'b1;
      chk("R6 set term sets when enabled", exp_q);
      mc_set_pt = 1'b0; #2;
   endtask

   task automatic t_priority;
      @(negedge ref_clk);
      set_cfg(0, 3);
      cfg_mc_sr_en = 1'b1;
      mc_set_pt = 1'b1; #2;
      mc_rst_pt = 1'b1; #2; exp_q = 1'b0;
      chk("R7 reset added over set reads 0", exp_q);
      mc_set_pt = 1'b0; #2; mc_rst_pt = 1'b0; #2;
      mc_rst_pt = 1'b1; #2;
      mc_set_pt = 1'b1; #2;
      chk("R7 set added over reset stays 0", exp_q);
      mc_set_pt = 1'b0; #2; mc_rst_pt = 1'b0; #2;
      @(negedge ref_clk);
      cfg_swap = 1'b1; #1;
      blk_init = 1'b1; #2; exp_q = 1'b1;
      mc_rst_pt = 1'b1; #2; exp_q = 1'b0;
      chk("R7 cell reset beats block-level preset", exp_q);
      blk_init = 1'b0; #2; mc_rst_pt = 1'b0; #2;
      cfg_swap = 1'b0; cfg_mc_sr_en = 1'b0; #1;
      pulse(0);
      exp_q = d;
      chk("R1 load resumes after async requests", exp_q);
   endtask

   initial begin
      #1 por_n = 1'b0;
      #2 chk("R8 reset state is 0 with swap=0", 1'b0);
      exp_q = 1'b0;
      @(negedge ref_clk);
      por_n = 1'b1;
      repeat (DLY - 1) @(posedge ref_clk);
      @(negedge ref_clk);
      d = 1'b1; pulse(0);
      chk("R8 initial hold blocks load", exp_q);
      @(posedge ref_clk);
      @(negedge ref_clk);
      pulse(0); exp_q = 1'b1;
      chk("R9 initial release allows load", exp_q);
      t_block_clocks();
      t_pt_clocks();
      t_shared_ground();
      t_clock_enable();
      t_block_init();
      t_cell_sr();
      t_priority();
      power_up(1'b1);
      power_up(1'b0);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule